// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block is the interrupt controller and context-stacking engine of a small 8-bit processor core. While the core is idle between instructions, the block waits for the instruction-complete strobe. At that strobe, if the interrupt mask bit of the incoming condition code is clear and any request line is high, it picks the most urgent source. The choice is then fixed. The block saves five bytes of processor context to a downward-growing byte stack and reads a two-byte handler address from a per-source vector slot. Finally it hands the core a new program counter and a condition code with the mask bit set.

A return strobe makes the block read the same five bytes back in the reverse order. It then delivers the saved program counter, accumulator, low index byte and condition code to the core together. All stack traffic and vector reads share one byte-wide memory port, with one access per cycle. A busy flag covers every cycle in which the block owns that port.

Top module: `irq_seq`

## Requirements
- R1: A request is taken only in a cycle where the block is idle, `insn_done` is high and bit 3 of `ccr_in` (the mask bit) is clear. Otherwise pending requests cause no bus activity and no acknowledge.
- R2: When several request lines are high at the deciding cycle, the lowest-numbered line is served.
- R3: The served source receives exactly one acknowledge pulse, one cycle long, in the first cycle after the deciding cycle. Request changes after that cycle, including higher-priority ones, do not change the source being served.
- R4: Entry performs five writes on consecutive cycles at addresses SP, SP-1, SP-2, SP-3, SP-4. The bytes written are PC[7:0], PC[15:8], X low byte, accumulator, and `ccr_in` as sampled (mask not yet set).
- R5: The stack pointer `sp_out` is 0x00FF after reset. It is 5 lower after an entry and 5 higher after a return.
- R6: After the pushes, the block reads vector address V and then V+1, with V = 0xFFFE - 2*k for source k. The byte at V becomes PC[15:8] and the byte at V+1 becomes PC[7:0].
- R7: The cycle after the second vector read asserts `pc_wr` and `ccr_wr` with `ax_wr` low. It presents the vector on `pc_out` and the saved condition code with bit 3 set on `ccr_out`.
- R8: A return reads SP+1 through SP+5 on five consecutive cycles, as CCR, accumulator, X low, PC high and PC low. The next cycle asserts `pc_wr`, `ccr_wr` and `ax_wr` with those values.
- R9: `rti_go` in an idle cycle starts a return even if a request could be taken in the same cycle. `rti_go` and `insn_done` have no effect while busy.
- R10: `busy` is high for exactly 8 cycles per entry and 6 cycles per return. It is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 4 | Request lines, bit 0 most urgent |
| irq_ack | output | 4 | One-cycle acknowledge for the served line |
| insn_done | input | 1 | Instruction boundary strobe |
| rti_go | input | 1 | Return-from-interrupt strobe |
| pc_in | input | 16 | Current program counter |
| x_in | input | 8 | Low byte of index register |
| a_in | input | 8 | Accumulator |
| ccr_in | input | 8 | Condition code register |
| pc_out | output | 16 | Program counter to load |
| x_out | output | 8 | Restored index low byte |
| a_out | output | 8 | Restored accumulator |
| ccr_out | output | 8 | Condition code to load |
| pc_wr | output | 1 | Load strobe for `pc_out` |
| ccr_wr | output | 1 | Load strobe for `ccr_out` |
| ax_wr | output | 1 | Load strobe for `a_out` and `x_out` |
| sp_out | output | 16 | Stack pointer |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid in the same cycle |
| mem_we | output | 1 | Write enable |
| mem_re | output | 1 | Read enable |
| busy | output | 1 | Sequence in progress |

## Verification
The bench targets a higher-priority line that rises mid-entry. A design that let the latch be displaced would acknowledge a second line and fetch the wrong vector. It also raises the return strobe in the same cycle as a takeable request. A design with the wrong precedence would push instead of pop, and so would corrupt the frame. A nested entry checks that the stack pointer keeps descending correctly from a non-reset value, and that the popped bytes land on the right outputs. A design that saved the condition code after setting the mask would leave the mask set after return, and the per-cycle compare of `ccr_out` shows this.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PUSH,
      ST_VHI,
      ST_VLO,
      ST_EFIN,
      ST_POP,
      ST_RFIN
   } seq_st_t;

   // Slot numbers inside the saved frame; slot order equals push order.
   localparam int FR_PCL = 0;
   localparam int FR_PCH = 1;
   localparam int FR_XL  = 2;
   localparam int FR_ACC = 3;
   localparam int FR_CCR = 4;
   localparam int FRAME  = 5;

endpackage

// File: rtl/irq_pick.sv
module irq_pick #(
   parameter int NSRC      = 4,
   parameter int IW        = 2,
   parameter bit LOW_FIRST = 1'b1
) (
   input  logic [NSRC-1:0] req,
   output logic            found,
   output logic [IW-1:0]   idx
);

   if (NSRC > (1 << IW)) begin : g_bad_iw
      $error("irq_pick: IW too narrow for NSRC");
   end

   if (LOW_FIRST) begin : g_low
      always_comb begin
         found = 1'b0;
         idx   = '0;
         for (int i = NSRC - 1; i >= 0; i--) begin
            if (req[i]) begin
               found = 1'b1;
               idx   = IW'(i);
            end
         end
      end
   end else begin : g_high
      always_comb begin
         found = 1'b0;
         idx   = '0;
         for (int i = 0; i < NSRC; i++) begin
            if (req[i]) begin
               found = 1'b1;
               idx   = IW'(i);
            end
         end
      end
   end

endmodule

// File: rtl/irq_vecgen.sv
module irq_vecgen #(
   parameter int            AW       = 16,
   parameter int            IW       = 2,
   parameter logic [AW-1:0] VEC_BASE = 16'hFFFE,
   parameter bit            DESCEND  = 1'b1
) (
   input  logic [IW-1:0] idx,
   output logic [AW-1:0] vaddr,
   output logic [AW-1:0] vaddr_nx
);

   logic [AW-1:0] step;
   assign step = AW'(idx) << 1;

   if (DESCEND) begin : g_down
      assign vaddr = VEC_BASE - step;
   end else begin : g_up
      assign vaddr = VEC_BASE + step;
   end

   assign vaddr_nx = vaddr + AW'(1);

endmodule

// File: rtl/irq_sp.sv
module irq_sp #(
   parameter int            AW       = 16,
   parameter logic [AW-1:0] SP_RESET = 16'h00FF
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          dec,
   input  logic          inc,
   output logic [AW-1:0] sp
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sp <= SP_RESET;
      end else if (dec) begin
         sp <= sp - AW'(1);
      end else if (inc) begin
         sp <= sp + AW'(1);
      end
   end

   // R5: pushes and pops never share a cycle
   assert_sp_onedir_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      !(dec && inc));

   // R5: a cycle with neither step leaves the pointer alone
   assert_sp_hold_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      (!dec && !inc) |=> $stable(sp));

endmodule

// File: rtl/irq_seq.sv
module irq_seq
   import irq_seq_pkg::*;
#(
   parameter int            NSRC        = 4,
   parameter int            DW          = 8,
   parameter int            AW          = 16,
   parameter logic [AW-1:0] SP_RESET    = 16'h00FF,
   parameter logic [AW-1:0] VEC_BASE    = 16'hFFFE,
   parameter int            MASK_BIT    = 3,
   parameter bit            VEC_DESCEND = 1'b1,
   parameter bit            LOW_FIRST   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NSRC-1:0]   irq_req,
   output logic [NSRC-1:0]   irq_ack,
   input  logic              insn_done,
   input  logic              rti_go,
   input  logic [2*DW-1:0]   pc_in,
   input  logic [DW-1:0]     x_in,
   input  logic [DW-1:0]     a_in,
   input  logic [DW-1:0]     ccr_in,
   output logic [2*DW-1:0]   pc_out,
   output logic [DW-1:0]     x_out,
   output logic [DW-1:0]     a_out,
   output logic [DW-1:0]     ccr_out,
   output logic              pc_wr,
   output logic              ccr_wr,
   output logic              ax_wr,
   output logic [AW-1:0]     sp_out,
   output logic [AW-1:0]     mem_addr,
   output logic [DW-1:0]     mem_wdata,
   input  logic [DW-1:0]     mem_rdata,
   output logic              mem_we,
   output logic              mem_re,
   output logic              busy
);

   localparam int            PW   = 2 * DW;
   localparam int            IW   = (NSRC > 1) ? $clog2(NSRC) : 1;
   localparam int            CW   = $clog2(FRAME);
   localparam logic [CW-1:0] LAST = CW'(FRAME - 1);
   localparam logic [DW-1:0] MASK = DW'(1) << MASK_BIT;

   if (NSRC < 1 || NSRC > 16) begin : g_bad_nsrc
      $error("irq_seq: NSRC must be 1..16");
   end
   if (MASK_BIT < 0 || MASK_BIT >= DW) begin : g_bad_mask
      $error("irq_seq: MASK_BIT outside the condition code");
   end
   if (AW < DW) begin : g_bad_aw
      $error("irq_seq: address narrower than data");
   end

   seq_st_t        st;
   logic [CW-1:0]  cnt;
   logic [IW-1:0]  src_q;
   logic [NSRC-1:0] ack_q;
   logic [DW-1:0]  vhi, vlo;
   logic [DW-1:0]  fr [FRAME];

   logic           pick_found;
   logic [IW-1:0]  pick_idx;
   logic [AW-1:0]  vaddr, vaddr_nx, sp;
   logic           take_ret, take_int;

   irq_pick #(
      .NSRC      (NSRC),
      .IW        (IW),
      .LOW_FIRST (LOW_FIRST)
   ) u_pick (
      .req   (irq_req),
      .found (pick_found),
      .idx   (pick_idx)
   );

   irq_vecgen #(
      .AW       (AW),
      .IW       (IW),
      .VEC_BASE (VEC_BASE),
      .DESCEND  (VEC_DESCEND)
   ) u_vec (
      .idx      (src_q),
      .vaddr    (vaddr),
      .vaddr_nx (vaddr_nx)
   );

   irq_sp #(
      .AW       (AW),
      .SP_RESET (SP_RESET)
   ) u_sp (
      .clk   (clk),
      .rst_n (rst_n),
      .dec   (st == ST_PUSH),
      .inc   (st == ST_POP),
      .sp    (sp)
   );

   // Return strobe wins over a takeable request in the same idle cycle.
   assign take_ret = (st == ST_IDLE) && rti_go;
   assign take_int = (st == ST_IDLE) && !rti_go && insn_done &&
                     !ccr_in[MASK_BIT] && pick_found;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= ST_IDLE;
         cnt   <= '0;
         src_q <= '0;
         ack_q <= '0;
         vhi   <= '0;
         vlo   <= '0;
         for (int i = 0; i < FRAME; i++) begin
            fr[i] <= '0;
         end
      end else begin
         ack_q <= '0;
         unique case (st)
            ST_IDLE: begin
               if (take_ret) begin
                  st  <= ST_POP;
                  cnt <= '0;
               end else if (take_int) begin
                  st         <= ST_PUSH;
                  cnt        <= '0;
                  src_q      <= pick_idx;
                  ack_q      <= NSRC'(1) << pick_idx;
                  fr[FR_PCL] <= pc_in[DW-1:0];
                  fr[FR_PCH] <= pc_in[PW-1:DW];
                  fr[FR_XL]  <= x_in;
                  fr[FR_ACC] <= a_in;
                  fr[FR_CCR] <= ccr_in;
               end
            end
            ST_PUSH: begin
               if (cnt == LAST) begin
                  st  <= ST_VHI;
                  cnt <= '0;
               end else begin
                  cnt <= cnt + CW'(1);
               end
            end
            ST_VHI: begin
               vhi <= mem_rdata;
               st  <= ST_VLO;
            end
            ST_VLO: begin
               vlo <= mem_rdata;
               st  <= ST_EFIN;
            end
            ST_EFIN: st <= ST_IDLE;
            ST_POP: begin
               fr[LAST - cnt] <= mem_rdata;
               if (cnt == LAST) begin
                  st  <= ST_RFIN;
                  cnt <= '0;
               end else begin
                  cnt <= cnt + CW'(1);
               end
            end
            ST_RFIN: st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_addr = sp;
      mem_we   = 1'b0;
      mem_re   = 1'b0;
      unique case (st)
         ST_PUSH: mem_we = 1'b1;
         ST_VHI: begin
            mem_re   = 1'b1;
            mem_addr = vaddr;
         end
         ST_VLO: begin
            mem_re   = 1'b1;
            mem_addr = vaddr_nx;
         end
         ST_POP: begin
            mem_re   = 1'b1;
            mem_addr = sp + AW'(1);
         end
         default: mem_addr = sp;
      endcase
   end

   assign mem_wdata = fr[cnt];
   assign irq_ack   = ack_q;
   assign busy      = (st != ST_IDLE);
   assign sp_out    = sp;
   assign pc_wr     = (st == ST_EFIN) || (st == ST_RFIN);
   assign ccr_wr    = pc_wr;
   assign ax_wr     = (st == ST_RFIN);
   assign pc_out    = (st == ST_EFIN) ? {vhi, vlo} : {fr[FR_PCH], fr[FR_PCL]};
   assign ccr_out   = (st == ST_EFIN) ? (fr[FR_CCR] | MASK) : fr[FR_CCR];
   assign a_out     = fr[FR_ACC];
   assign x_out     = fr[FR_XL];

   // R1: an acknowledge follows a boundary with the mask clear
   assert_sample_gate_R1 : assert property (@(posedge clk) disable iff (!rst_n)
      (|irq_ack) |-> $past(insn_done && !ccr_in[MASK_BIT]));

   // R2: the chosen line is actually requesting
   assert_pick_valid_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      pick_found |-> irq_req[pick_idx]);

   // R3: at most one line acknowledged, for a single cycle
   assert_ack_onehot_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(irq_ack));
   assert_ack_pulse_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      (|irq_ack) |=> (irq_ack == '0));

   // R4: each push moves the pointer one below the written address
   assert_push_step_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> (sp_out == $past(mem_addr) - AW'(1)));
   assert_bus_excl_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_we && mem_re));

   // R6: the second vector read is at the next address
   assert_vec_pair_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_VLO) |-> (mem_addr == $past(mem_addr) + AW'(1)));

   // R7: entry completion always hands over a masked condition code
   assert_mask_set_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      (pc_wr && !ax_wr) |-> ccr_out[MASK_BIT]);

   // R8: each pop leaves the pointer on the address just read
   assert_pop_step_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      (mem_re && st == ST_POP) |=> (sp_out == $past(mem_addr)));

   // R10: acknowledge only inside a sequence; busy ends right after a load
   assert_ack_busy_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      (|irq_ack) |-> busy);
   assert_busy_end_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(pc_wr));

endmodule

// File: tb/sim_irq_seq.sv
module sim_irq_seq;

   typedef struct {
      bit          busy, we, re, pcw, ccrw, axw;
      logic [15:0] addr, sp, pc;
      logic [7:0]  wd, ccr, a, x;
      logic [3:0]  ack;
      int          tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  irq_req = '0;
   logic [3:0]  irq_ack;
   logic        insn_done = 1'b0;
   logic        rti_go = 1'b0;
   logic [15:0] pc_in = '0;
   logic [7:0]  x_in = '0, a_in = '0, ccr_in = '0;
   logic [15:0] pc_out;
   logic [7:0]  x_out, a_out, ccr_out;
   logic        pc_wr, ccr_wr, ax_wr;
   logic [15:0] sp_out, mem_addr;
   logic [7:0]  mem_wdata, mem_rdata;
   logic        mem_we, mem_re, busy;

   logic [7:0]  bmem [256];
   logic [7:0]  mstk [256];
   logic [15:0] msp = 16'h00FF;
   exp_t        q[$];
   logic [3:0]  last_ack = '0;
   bit          armed = 1'b0;
   bit          ended = 1'b0;
   int          ncmp = 0;
   int          nmis = 0;
   int          cycles = 0;

   always #10 clk = ~clk;

   irq_seq u0 (
      .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_ack(irq_ack),
      .insn_done(insn_done), .rti_go(rti_go), .pc_in(pc_in), .x_in(x_in),
      .a_in(a_in), .ccr_in(ccr_in), .pc_out(pc_out), .x_out(x_out),
      .a_out(a_out), .ccr_out(ccr_out), .pc_wr(pc_wr), .ccr_wr(ccr_wr),
      .ax_wr(ax_wr), .sp_out(sp_out), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_we(mem_we),
      .mem_re(mem_re), .busy(busy)
   );

   // bench memory: stack page plus a computed vector area
   initial for (int i = 0; i < 256; i++) begin
      bmem[i] = 8'h00;
      mstk[i] = 8'h00;
   end

   always_comb begin
      if (mem_addr[15:8] == 8'h00)   mem_rdata = bmem[mem_addr[7:0]];
      else if (mem_addr >= 16'hFF00) mem_rdata = mem_addr[7:0] ^ 8'h5A;
      else                           mem_rdata = 8'h00;
   end

   always @(posedge clk) if (mem_we && mem_addr[15:8] == 8'h00)
      bmem[mem_addr[7:0]] <= mem_wdata;

   function automatic logic [7:0] vbyte(logic [15:0] a);
      return a[7:0] ^ 8'h5A;
   endfunction

   function automatic exp_t blank(int tag);
      exp_t e;
      e.busy = 0; e.we = 0; e.re = 0; e.pcw = 0; e.ccrw = 0; e.axw = 0;
      e.addr = '0; e.sp = msp; e.pc = '0; e.wd = '0; e.ccr = '0;
      e.a = '0; e.x = '0; e.ack = '0; e.tag = tag;
      return e;
   endfunction

   // entry script: R2 R4 R6 R7
   function automatic void build_ent(int k);
      exp_t e;
      logic [7:0]  b [5];
      logic [15:0] s = msp;
      logic [15:0] v = 16'hFFFE - 16'(2 * k);
      b[0] = pc_in[7:0]; b[1] = pc_in[15:8]; b[2] = x_in; b[3] = a_in; b[4] = ccr_in;
      for (int i = 0; i < 5; i++) begin
         e = blank(i == 0 ? 2 : 4);
         e.busy = 1; e.we = 1; e.addr = s - 16'(i); e.wd = b[i]; e.sp = s - 16'(i);
         if (i == 0) e.ack = 4'(1 << k);
         mstk[e.addr[7:0]] = b[i];
         q.push_back(e);
      end
      msp = s - 16'd5;
      e = blank(6); e.busy = 1; e.re = 1; e.addr = v; q.push_back(e);
      e = blank(6); e.busy = 1; e.re = 1; e.addr = v + 16'd1; q.push_back(e);
      e = blank(7); e.busy = 1; e.pcw = 1; e.ccrw = 1;
      e.pc = {vbyte(v), vbyte(v + 16'd1)}; e.ccr = ccr_in | 8'h08;
      q.push_back(e);
   endfunction

   // return script: R8
   function automatic void build_ret();
      exp_t e;
      logic [15:0] s = msp;
      for (int i = 0; i < 5; i++) begin
         e = blank(8); e.busy = 1; e.re = 1; e.addr = s + 16'(1 + i); e.sp = s + 16'(i);
         q.push_back(e);
      end
      msp = s + 16'd5;
      e = blank(8); e.busy = 1; e.pcw = 1; e.ccrw = 1; e.axw = 1;
      e.ccr = mstk[8'(s + 16'd1)]; e.a = mstk[8'(s + 16'd2)]; e.x = mstk[8'(s + 16'd3)];
      e.pc = {mstk[8'(s + 16'd4)], mstk[8'(s + 16'd5)]};
      q.push_back(e);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         q.delete();
         msp = 16'h00FF;
      end else if (q.size() == 0) begin
         if (rti_go) build_ret();                       // R9 precedence
         else if (insn_done && !ccr_in[3] && irq_req != 0) begin
            for (int k = 0; k < 4; k++) if (irq_req[k]) begin build_ent(k); break; end
         end
      end else begin
         void'(q.pop_front());
      end
   end

   task automatic chk(int tag, logic [31:0] act, logic [31:0] exp, string what);
      ncmp++;
      if (act !== exp) begin
         nmis++;
         $display("FAIL R%0d %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) if (armed && rst_n) begin
      exp_t e;
      e = (q.size() != 0) ? q[0] : blank(1);          // R1 idle expectation
      if (irq_ack != 0) last_ack = irq_ack;
      chk(10, 32'(busy), 32'(e.busy), "busy");
      chk(e.tag == 2 ? 2 : 3, 32'(irq_ack), 32'(e.ack), "ack");
      chk(e.tag, 32'(mem_we), 32'(e.we), "mem_we");
      chk(e.tag, 32'(mem_re), 32'(e.re), "mem_re");
      if (e.we || e.re) chk(e.tag, 32'(mem_addr), 32'(e.addr), "mem_addr");
      if (e.we) chk(e.tag, 32'(mem_wdata), 32'(e.wd), "mem_wdata");
      chk(5, 32'(sp_out), 32'(e.sp), "sp_out");
      chk(e.tag, 32'(pc_wr), 32'(e.pcw), "pc_wr");
      chk(e.tag, 32'(ccr_wr), 32'(e.ccrw), "ccr_wr");
      chk(e.tag, 32'(ax_wr), 32'(e.axw), "ax_wr");
      if (e.pcw) chk(e.tag, 32'(pc_out), 32'(e.pc), "pc_out");
      if (e.ccrw) chk(e.tag, 32'(ccr_out), 32'(e.ccr), "ccr_out");
      if (e.axw) begin
         chk(e.tag, 32'(a_out), 32'(e.a), "a_out");
         chk(e.tag, 32'(x_out), 32'(e.x), "x_out");
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000 && !ended) begin
         ended = 1'b1;
         ncmp++; nmis++;
         $display("FAIL R10 watchdog: actual %0d expected below 100000 cycles", cycles);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nmis);
         $finish;
      end
   end

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      tick(3);
      rst_n = 1'b1;
      armed = 1'b1;
      chk(5, 32'(sp_out), 32'h00FF, "sp after reset");
      chk(10, 32'(busy), 32'h0, "busy after reset");

      // R1: pending request, no boundary
      irq_req = 4'b0100; pc_in = 16'h1234; x_in = 8'h56; a_in = 8'h78; ccr_in = 8'h00;
      tick(4);
      // R1: boundary with mask set
      insn_done = 1'b1; ccr_in = 8'h08;
      tick(1);
      insn_done = 1'b0;
      tick(3);
      // plain entry of line 2, then return
      insn_done = 1'b1; ccr_in = 8'h00;
      tick(1);
      insn_done = 1'b0;
      tick(12);
      irq_req = 4'b0000;
      rti_go = 1'b1;
      tick(1);
      rti_go = 1'b0;
      tick(8);

      // R2 and R3: two lines, a more urgent one rises mid-entry; R9 rti while busy
      irq_req = 4'b1010; pc_in = 16'hABCD; x_in = 8'h11; a_in = 8'h22; ccr_in = 8'h01;
      insn_done = 1'b1;
      tick(1);
      insn_done = 1'b0;
      tick(1);
      irq_req = 4'b0001; rti_go = 1'b1;
      tick(1);
      rti_go = 1'b0;
      tick(10);
      chk(3, 32'(last_ack), 32'b0010, "served line kept");
      // nested entry from a lowered stack pointer
      ccr_in = 8'h00; pc_in = 16'h5678; x_in = 8'h9A; a_in = 8'hBC;
      insn_done = 1'b1;
      tick(1);
      insn_done = 1'b0;
      tick(12);
      chk(2, 32'(last_ack), 32'b0001, "nested line");
      irq_req = 4'b0000;
      rti_go = 1'b1; tick(1); rti_go = 1'b0; tick(8);
      rti_go = 1'b1; tick(1); rti_go = 1'b0; tick(8);

      // R9: return strobe and takeable request in the same cycle
      irq_req = 4'b0100; pc_in = 16'h0F0E; x_in = 8'h33; a_in = 8'h44; ccr_in = 8'h04;
      insn_done = 1'b1; tick(1); insn_done = 1'b0; tick(12);
      ccr_in = 8'h00; pc_in = 16'h2222;
      rti_go = 1'b1; insn_done = 1'b1;
      tick(1);
      rti_go = 1'b0; insn_done = 1'b0;
      chk(9, 32'(irq_ack), 32'h0, "no ack when return wins");
      chk(9, 32'(mem_re), 32'h1, "return pop started");
      tick(8);
      insn_done = 1'b1; tick(1); insn_done = 1'b0; tick(12);
      irq_req = 4'b0000;
      rti_go = 1'b1; tick(1); rti_go = 1'b0; tick(8);

      if (!ended) begin
         ended = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nmis);
         $finish;
      end
   end

endmodule